// File: doc/BRIEF.md
# Programmable Functional Unit Dispatch

This block is a stateless custom execution unit that sits beside a processor register file, in the same position as an extra arithmetic unit. A custom instruction presents an 11-bit function identifier together with two 32-bit register operands. The unit compares that identifier against the one currently resident in its programmable array. When they agree, the selected operation is evaluated combinationally and the result returns in the same cycle. When they disagree, or when nothing has been loaded yet, the unit raises a fault so that a trap routine can install the missing function and re-issue the instruction.

The resident function is written through a configuration port. That port carries the identifier and a 3-bit operation code that picks one of eight built-in operations. The only storage is this configuration: a loaded flag, the identifier and the operation code. No operand or result is kept between dispatches, so a context switch never has to save or restore the unit.

Top module: `pfu_dispatch`

## Requirements
- R1: With a function loaded and `disp_fid` equal to the resident identifier, a dispatch (`disp_valid`=1) drives `res_valid`=1 and the operation result on `res_data` in the same cycle.
- R2: A dispatch whose identifier differs from the resident identifier drives `fault`=1 and `res_valid`=0 in the same cycle.
- R3: After reset nothing is loaded, and every dispatch faults whatever its identifier is (0 and 2047 included). Only a configuration write sets the loaded flag.
- R4: `fault` and `res_valid` are never both 1 in the same cycle.
- R5: Without a dispatch (`disp_valid`=0), both `fault` and `res_valid` are 0, whatever the other inputs are.
- R6: `res_data` is all zeros whenever `res_valid` is 0.
- R7: A configuration write (`cfg_we`=1) takes effect from the next clock edge. A dispatch in the same cycle as the write uses the previous configuration. Without a write, the configuration does not change.
- R8: The operation code selects the result: 0 a+b, 1 a-b, 2 a AND b, 3 a OR b, 4 a XOR b, 5 a shifted left by b[4:0], 6 a rotated left by b[4:0], 7 the unsigned maximum of a and b. Sums and differences wrap modulo 2^32.
- R9: All 11 identifier bits take part in the comparison, so identifiers that differ only in bit 10 or only in bit 0 do not match.
- R10: The result depends only on the current operands and configuration. Back-to-back dispatches with different operands each return their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the loaded flag |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fid | input | 11 | Identifier to make resident |
| cfg_op | input | 3 | Operation code to make resident |
| disp_valid | input | 1 | Custom instruction dispatch this cycle |
| disp_fid | input | 11 | Identifier carried by the instruction |
| disp_a | input | 32 | First register operand |
| disp_b | input | 32 | Second register operand |
| res_valid | output | 1 | Result on res_data is valid |
| res_data | output | 32 | Combinational result, zero when not valid |
| fault | output | 1 | Identifier mismatch or unloaded array; trap request |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, an 11-bit identifier and three operation-code bits. These widths put the extremes of the identifier space, 0 and 2047, within reach, as well as identifiers that differ only in the top bit. Shift and rotate amounts cover 0 and 31, and the sums carry out of bit 31. A behavioural model of the loaded flag, identifier and operation is compared with all three outputs on every cycle. This includes the cycles in which a configuration write and a dispatch coincide. It also includes a long pseudo-random run that alternates matching and mismatching identifiers.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
    localparam int OP_W    = 3;
    localparam int NUM_OPS = 1 << OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_ROTL = 3'd6,
        OP_MAXU = 3'd7
    } pfu_op_e;
endpackage

// File: rtl/pfu_cfg_store.sv
module pfu_cfg_store
    import pfu_pkg::*;
#(
    parameter int FID_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [FID_W-1:0] cfg_fid,
    input  pfu_op_e          cfg_op,
    output logic             loaded,
    output logic [FID_W-1:0] res_fid,
    output pfu_op_e          res_op
);
    typedef struct packed {
        logic             vld;
        logic [FID_W-1:0] fid;
        pfu_op_e          op;
    } cfg_t;

    cfg_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (cfg_we) begin
            cur_d.vld = 1'b1;
            cur_d.fid = cfg_fid;
            cur_d.op  = cfg_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{vld: 1'b0, fid: '0, op: OP_ADD};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign loaded  = cur_q.vld;
    assign res_fid = cur_q.fid;
    assign res_op  = cur_q.op;

    // R7: configuration holds without a write
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cur_q));

    // R3: loaded flag only rises after a write
    p_load_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.vld) |-> $past(cfg_we));
endmodule

// File: rtl/pfu_match.sv
module pfu_match #(
    parameter int FID_W = 11
) (
    input  logic             loaded,
    input  logic [FID_W-1:0] res_fid,
    input  logic             disp_valid,
    input  logic [FID_W-1:0] disp_fid,
    output logic             hit,
    output logic             miss
);
    logic same_id;

    always_comb begin
        same_id = (res_fid == disp_fid);
        hit     = disp_valid &  loaded &  same_id;
        miss    = disp_valid & ~(loaded & same_id);
    end
endmodule

// File: rtl/pfu_op_array.sv
module pfu_op_array
    import pfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  pfu_op_e           op_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0]   cand [NUM_OPS];
    logic [SH_W-1:0]     sh;
    logic [2*DATA_W-1:0] dbl;

    assign sh  = b[SH_W-1:0];
    assign dbl = {a, a} << sh;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        if (k == int'(OP_ADD)) begin : g_add
            assign cand[k] = a + b;
        end else if (k == int'(OP_SUB)) begin : g_sub
            assign cand[k] = a - b;
        end else if (k == int'(OP_AND)) begin : g_and
            assign cand[k] = a & b;
        end else if (k == int'(OP_OR)) begin : g_or
            assign cand[k] = a | b;
        end else if (k == int'(OP_XOR)) begin : g_xor
            assign cand[k] = a ^ b;
        end else if (k == int'(OP_SHL)) begin : g_shl
            assign cand[k] = a << sh;
        end else if (k == int'(OP_ROTL)) begin : g_rotl
            assign cand[k] = dbl[2*DATA_W-1:DATA_W];
        end else begin : g_maxu
            assign cand[k] = (a > b) ? a : b;
        end
    end

    assign y = cand[op_sel];
endmodule

// File: rtl/pfu_dispatch.sv
module pfu_dispatch
    import pfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FID_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FID_W-1:0]  cfg_fid,
    input  logic [OP_W-1:0]   cfg_op,
    input  logic              disp_valid,
    input  logic [FID_W-1:0]  disp_fid,
    input  logic [DATA_W-1:0] disp_a,
    input  logic [DATA_W-1:0] disp_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              fault
);
    logic              loaded;
    logic [FID_W-1:0]  res_fid;
    pfu_op_e           res_op;
    logic              hit;
    logic              miss;
    logic [DATA_W-1:0] raw_y;

    pfu_cfg_store #(.FID_W(FID_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_fid (cfg_fid),
        .cfg_op  (pfu_op_e'(cfg_op)),
        .loaded  (loaded),
        .res_fid (res_fid),
        .res_op  (res_op)
    );

    pfu_match #(.FID_W(FID_W)) u_match (
        .loaded     (loaded),
        .res_fid    (res_fid),
        .disp_valid (disp_valid),
        .disp_fid   (disp_fid),
        .hit        (hit),
        .miss       (miss)
    );

    pfu_op_array #(.DATA_W(DATA_W)) u_ops (
        .op_sel (res_op),
        .a      (disp_a),
        .b      (disp_b),
        .y      (raw_y)
    );

    assign res_valid = hit;
    assign fault     = miss;
    assign res_data  = hit ? raw_y : '0;

    // R4: fault and result never coincide
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && res_valid));

    // R5: quiet outputs without a dispatch
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |-> (!fault && !res_valid));

    // R6: data is zero when not valid
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_data == '0));

    // R3: unloaded array always faults
    p_unloaded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !loaded) |-> fault);

    // R2: identifier mismatch faults
    p_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && (disp_fid != res_fid)) |-> (fault && !res_valid));
endmodule

// File: tb/sim_pfu_dispatch.sv
module sim_pfu_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [10:0] cfg_fid = '0;
    logic [2:0]  cfg_op = '0;
    logic        disp_valid = 1'b0;
    logic [10:0] disp_fid = '0;
    logic [31:0] disp_a = '0;
    logic [31:0] disp_b = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural model of the resident configuration
    bit          m_vld = 1'b0;
    int unsigned m_fid = 0;
    int unsigned m_op  = 0;

    always #5 clk = ~clk;

    pfu_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fid(cfg_fid),
        .cfg_op(cfg_op), .disp_valid(disp_valid), .disp_fid(disp_fid),
        .disp_a(disp_a), .disp_b(disp_b), .res_valid(res_valid),
        .res_data(res_data), .fault(fault)
    );

    function automatic logic [31:0] ref_op(int unsigned op, logic [31:0] a, logic [31:0] b);
        int s;
        s = int'(b[4:0]);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << s;
            6: return (s == 0) ? a : ((a << s) | (a >> (32 - s)));
            default: return (a > b) ? a : b;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at negedge, compare mid-cycle, update model at posedge
    task automatic step(string req, bit we, int unsigned cf, int unsigned co,
                        bit dv, int unsigned df, logic [31:0] a, logic [31:0] b);
        bit          ef, ev;
        logic [31:0] ed;
        @(negedge clk);
        cfg_we = we; cfg_fid = cf[10:0]; cfg_op = co[2:0];
        disp_valid = dv; disp_fid = df[10:0]; disp_a = a; disp_b = b;
        #1;
        ef = dv && (!m_vld || (df != m_fid));
        ev = dv && !ef;
        ed = ev ? ref_op(m_op, a, b) : 32'h0;
        check(req, "fault", {31'b0, fault}, {31'b0, ef});
        check(req, "res_valid", {31'b0, res_valid}, {31'b0, ev});
        check(req, "res_data", res_data, ed);
        @(posedge clk);
        if (we) begin
            m_vld = 1'b1; m_fid = cf; m_op = co;
        end
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state: unloaded, all identifiers fault
        step("R3", 0, 0, 0, 1, 0, 32'h1, 32'h2);
        step("R3", 0, 0, 0, 1, 2047, 32'h1, 32'h2);
        // R5 idle with busy operands
        step("R5", 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h1234_5678);
        // R7 write and dispatch in the same cycle: old (unloaded) config used
        step("R7", 1, 11'h155, 0, 1, 11'h155, 32'h10, 32'h20);
        // R1 match, add
        step("R1", 0, 0, 0, 1, 11'h155, 32'hFFFF_FFFF, 32'h2);
        // R9 bit 10 and bit 0 differences fault (R2)
        step("R9", 0, 0, 0, 1, 11'h555, 32'h3, 32'h4);
        step("R9", 0, 0, 0, 1, 11'h154, 32'h3, 32'h4);
        // R8 each operation code with edge operands (R10 back to back)
        for (int k = 0; k < 8; k++) begin
            step("R8", 1, (k * 257) % 2048, k, 0, 0, 32'h0, 32'h0);
            step("R8", 0, 0, 0, 1, (k * 257) % 2048, 32'h8000_0001, 32'h0000_001F);
            step("R10", 0, 0, 0, 1, (k * 257) % 2048, 32'hDEAD_BEEF, 32'h0000_0000);
            step("R10", 0, 0, 0, 1, (k * 257) % 2048, 32'h0000_0005, 32'hFFFF_FFE4);
            step("R2", 0, 0, 0, 1, ((k * 257) + 1) % 2048, 32'h5, 32'h6);
        end
        // R7 reconfigure to 2047/xor while dispatching old id: old function answers
        step("R7", 1, 2047, 4, 1, 1799, 32'h0F0F_0F0F, 32'h00FF_00FF);
        step("R7", 0, 0, 0, 1, 1799, 32'h0F0F_0F0F, 32'h00FF_00FF);
        step("R1", 0, 0, 0, 1, 2047, 32'h0F0F_0F0F, 32'h00FF_00FF);
        // R6 idle after a hit
        step("R6", 0, 0, 0, 0, 2047, 32'hAAAA_AAAA, 32'h5555_5555);
        // pseudo-random run
        lf = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[7:0] < 8'd20)
                step("R7", 1, int'(lf[18:8]), int'(lf[22:20]), lf[23], int'(lf[18:8]) ^ 1, lf, ~lf);
            else if (lf[8])
                step("R1", 0, 0, 0, 1, m_fid, lf, {lf[15:0], lf[31:16]});
            else
                step("R4", 0, 0, 0, lf[9], int'(lf[20:10]), lf, lf ^ 32'h3C3C_3C3C);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule